// File: doc/BRIEF.md
# Exception entry state generator

This combinational block works out the machine state that a 64-bit processor loads when it takes a program-check or a system-call interrupt. The current machine state register (MSR), a 5-bit trap-type code, the current program counter and a 2-bit operation select go in. The block returns four values, each with its own valid strobe:

- the new MSR;
- the new saved status register 1 (SRR1);
- the saved return address (SRR0);
- the interrupt vector that becomes the next instruction address.

All registers use big-endian bit numbering. Architectural bit n is stored at physical index 63-n, so a field covering architectural bits s..e sits in the physical slice [63-e:63-s].

The new MSR is a copy of the old one with a fixed set of bits forced. SRR1 is a copy of the old MSR with reserved bits cleared and the cause bits written in.

The operation select uses this encoding:

| Code | Operation |
|------|-----------|
| 00 | none |
| 01 | program check |
| 10 | system call |
| 11 | none |

The fixed set of forced MSR bits includes an implementation-defined bit, UND. UND is placed at reserved architectural bit 5 (physical 58), and the parameter UND_POS can move it.

Top module: `exc_entry_gen`

## Requirements
- R1: When op_i is 00 or 11, every output is zero: the four data outputs and the four valid strobes.
- R2: When op_i is 01 or 10, msr_ok_o, srr1_ok_o, srr0_ok_o and nia_ok_o are all 1.
- R3: When active, msr_o has these architectural bits cleared: TM 31, VEC 38, VSX 40, EE 48, PR 49, FP 50, FE0 52, TE 53..54, FE1 55, IR 58, DR 59, PMM 61, RI 62, and UND at bit 5.
- R4: When active, msr_o has SF (architectural bit 0) and LE (architectural bit 63) set to 1.
- R5: When active, every MSR bit not named in R3 or R4 is copied unchanged from msr_i. This includes HV (bit 3), ME (bit 51) and the transaction-state bits 34..35.
- R6: When active, srr1_o is a copy of msr_i with architectural bits 33..36 and bit 42 cleared. Bits outside 33..36 and 42..47 are copied unchanged.
- R7: For a program check, srr1_o takes its cause bits from the trap type as follows: bit 43 = tt_i[0], bit 44 = tt_i[4], bit 45 = tt_i[1], bit 47 = tt_i[3]. tt_i[2] has no effect.
- R8: For a program check, srr1_o bit 46 is 1 exactly when tt_i equals 0.
- R9: For a system call, srr1_o bits 42..47 are all 0, and tt_i has no effect.
- R10: When active, srr0_o equals pc_i. nia_o equals VEC_PROG (default 0x700) for a program check and VEC_SC (default 0xC00) for a system call.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 2 | Operation select: 00 none, 01 program check, 10 system call, 11 none |
| msr_i | input | 64 | Current MSR |
| tt_i | input | 5 | Trap-type code |
| pc_i | input | 64 | Current instruction address |
| msr_o | output | 64 | New MSR |
| msr_ok_o | output | 1 | New MSR valid |
| srr1_o | output | 64 | New SRR1 |
| srr1_ok_o | output | 1 | New SRR1 valid |
| srr0_o | output | 64 | Saved return address |
| srr0_ok_o | output | 1 | Saved return address valid |
| nia_o | output | 64 | Interrupt vector |
| nia_ok_o | output | 1 | Interrupt vector valid |

## Verification
The bench builds the block with its default parameters: UND at architectural bit 5 and vectors 0x700 and 0xC00.

Each trap-type bit is driven alone, and the all-zero trap-type code is driven as well. This shows that each cause bit lands on the right SRR1 position and that bit 46 is set only when the code is zero.

All-zero, all-ones and mixed MSR patterns show, on both outputs, that every forced bit is forced and that every other bit is copied. The two idle encodings and a system call with a non-zero trap type show that the trap type is ignored wherever it should be.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
    localparam int XLEN = 64;
    localparam int TT_W = 5;

    typedef enum logic [1:0] {
        OP_NONE  = 2'b00,
        OP_PROG  = 2'b01,
        OP_SC    = 2'b10,
        OP_NONE2 = 2'b11
    } exc_op_e;

    // architectural MSR bit positions (bit 0 is the MSB)
    localparam int A_SF  = 0;
    localparam int A_HV  = 3;
    localparam int A_TM  = 31;
    localparam int A_VEC = 38;
    localparam int A_VSX = 40;
    localparam int A_EE  = 48;
    localparam int A_PR  = 49;
    localparam int A_FP  = 50;
    localparam int A_ME  = 51;
    localparam int A_FE0 = 52;
    localparam int A_TES = 53;
    localparam int A_TEE = 54;
    localparam int A_FE1 = 55;
    localparam int A_IR  = 58;
    localparam int A_DR  = 59;
    localparam int A_PMM = 61;
    localparam int A_RI  = 62;
    localparam int A_LE  = 63;

    // SRR1 cause positions
    localparam int C_TMBAD = 42;
    localparam int C_FP    = 43;
    localparam int C_ILL   = 44;
    localparam int C_PRIV  = 45;
    localparam int C_TRAP  = 46;
    localparam int C_ADDR  = 47;

    typedef logic [XLEN-1:0] xword_t;

    typedef struct packed {
        xword_t msr;
        xword_t srr1;
        xword_t srr0;
        xword_t nia;
        logic   ok;
    } exc_result_t;

    // physical index of an architectural bit
    function automatic int phys(input int n);
        return XLEN - 1 - n;
    endfunction

    function automatic xword_t abit(input int n);
        xword_t r;
        r = '0;
        r[phys(n)] = 1'b1;
        return r;
    endfunction

    // mask of architectural bits s..e inclusive
    function automatic xword_t afield(input int s, input int e);
        xword_t r;
        r = '0;
        for (int i = s; i <= e; i++) r |= abit(i);
        return r;
    endfunction
endpackage

// File: rtl/exc_msr_forcer.sv
module exc_msr_forcer
    import exc_entry_pkg::*;
#(
    parameter int UND_POS = 5
) (
    input  xword_t msr_i,
    output xword_t msr_o
);
    localparam xword_t CLR_MASK =
        abit(A_IR) | abit(A_DR) | abit(A_FE0) | abit(A_FE1) |
        abit(A_EE) | abit(A_RI) | abit(A_TM)  | abit(A_VEC) |
        abit(A_VSX)| abit(A_PR) | abit(A_FP)  | abit(A_PMM) |
        afield(A_TES, A_TEE) | abit(UND_POS);
    localparam xword_t SET_MASK = abit(A_SF) | abit(A_LE);

    assign msr_o = (msr_i & ~CLR_MASK) | SET_MASK;
endmodule

// File: rtl/exc_srr1_builder.sv
module exc_srr1_builder
    import exc_entry_pkg::*;
(
    input  xword_t           msr_i,
    input  logic [TT_W-1:0]  tt_i,
    input  logic             is_prog_i,
    output xword_t           srr1_o
);
    localparam xword_t CLR_MASK = afield(33, 36) | afield(C_TMBAD, C_ADDR);

    xword_t cause;
    logic   tt_unused;

    assign tt_unused = tt_i[2];

    always_comb begin
        cause = '0;
        if (is_prog_i) begin
            cause[phys(C_FP)]   = tt_i[0];
            cause[phys(C_ILL)]  = tt_i[4];
            cause[phys(C_PRIV)] = tt_i[1];
            cause[phys(C_TRAP)] = (tt_i == '0);
            cause[phys(C_ADDR)] = tt_i[3];
        end
    end

    assign srr1_o = (msr_i & ~CLR_MASK) | cause;
endmodule

// File: rtl/exc_vector_sel.sv
module exc_vector_sel
    import exc_entry_pkg::*;
#(
    parameter xword_t VEC_PROG = 64'h700,
    parameter xword_t VEC_SC   = 64'hC00
) (
    input  exc_op_e op_i,
    output logic    active_o,
    output logic    is_prog_o,
    output xword_t  nia_o
);
    always_comb begin
        active_o  = 1'b0;
        is_prog_o = 1'b0;
        nia_o     = '0;
        unique case (op_i)
            OP_PROG: begin
                active_o  = 1'b1;
                is_prog_o = 1'b1;
                nia_o     = VEC_PROG;
            end
            OP_SC: begin
                active_o = 1'b1;
                nia_o    = VEC_SC;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/exc_entry_gen.sv
module exc_entry_gen
    import exc_entry_pkg::*;
#(
    parameter int     UND_POS  = 5,
    parameter xword_t VEC_PROG = 64'h700,
    parameter xword_t VEC_SC   = 64'hC00
) (
    input  logic [1:0]      op_i,
    input  logic [XLEN-1:0] msr_i,
    input  logic [TT_W-1:0] tt_i,
    input  logic [XLEN-1:0] pc_i,
    output logic [XLEN-1:0] msr_o,
    output logic            msr_ok_o,
    output logic [XLEN-1:0] srr1_o,
    output logic            srr1_ok_o,
    output logic [XLEN-1:0] srr0_o,
    output logic            srr0_ok_o,
    output logic [XLEN-1:0] nia_o,
    output logic            nia_ok_o
);
    logic        active;
    logic        is_prog;
    xword_t      nia_raw;
    xword_t      msr_raw;
    xword_t      srr1_raw;
    exc_result_t res;

    exc_vector_sel #(.VEC_PROG(VEC_PROG), .VEC_SC(VEC_SC)) u_vec (
        .op_i      (exc_op_e'(op_i)),
        .active_o  (active),
        .is_prog_o (is_prog),
        .nia_o     (nia_raw)
    );

    exc_msr_forcer #(.UND_POS(UND_POS)) u_msr (
        .msr_i (msr_i),
        .msr_o (msr_raw)
    );

    exc_srr1_builder u_srr1 (
        .msr_i     (msr_i),
        .tt_i      (tt_i),
        .is_prog_i (is_prog),
        .srr1_o    (srr1_raw)
    );

    always_comb begin
        res = '0;
        if (active) begin
            res.msr  = msr_raw;
            res.srr1 = srr1_raw;
            res.srr0 = pc_i;
            res.nia  = nia_raw;
            res.ok   = 1'b1;
        end
    end

    assign msr_o     = res.msr;
    assign srr1_o    = res.srr1;
    assign srr0_o    = res.srr0;
    assign nia_o     = res.nia;
    assign msr_ok_o  = res.ok;
    assign srr1_ok_o = res.ok;
    assign srr0_ok_o = res.ok;
    assign nia_ok_o  = res.ok;
endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk
    import exc_entry_pkg::*;
(
    input logic [1:0]      op_i,
    input logic [XLEN-1:0] msr_i,
    input logic [TT_W-1:0] tt_i,
    input logic [XLEN-1:0] pc_i,
    input logic [XLEN-1:0] msr_o,
    input logic            msr_ok_o,
    input logic [XLEN-1:0] srr1_o,
    input logic            srr1_ok_o,
    input logic [XLEN-1:0] srr0_o,
    input logic            srr0_ok_o,
    input logic [XLEN-1:0] nia_o,
    input logic            nia_ok_o
);
    logic act;
    assign act = (op_i == 2'b01) || (op_i == 2'b10);

    always_comb begin
        if (!act) begin
            a_r1_idle_zero: assert ((msr_o | srr1_o | srr0_o | nia_o) == '0
                && !msr_ok_o && !srr1_ok_o && !srr0_ok_o && !nia_ok_o)
                else $error("R1 idle outputs not zero");
        end
        if (act) begin
            a_r2_strobes: assert (msr_ok_o && srr1_ok_o && srr0_ok_o && nia_ok_o)
                else $error("R2 strobe missing");
            a_r4_sf_le: assert (msr_o[63] && msr_o[0])
                else $error("R4 SF/LE not set");
            a_r3_ee_pr: assert (!msr_o[15] && !msr_o[14] && msr_o[10:9] == 2'b00)
                else $error("R3 EE/PR/TE not cleared");
            a_r5_hv_me: assert (msr_o[60] == msr_i[60] && msr_o[12] == msr_i[12])
                else $error("R5 HV/ME not copied");
            a_r6_srr1_clear: assert (srr1_o[30:27] == 4'b0 && !srr1_o[21])
                else $error("R6 SRR1 reserved bits");
            a_r10_srr0: assert (srr0_o == pc_i)
                else $error("R10 SRR0 mismatch");
        end
        if (op_i == 2'b01) begin
            a_r8_trap_bit: assert (srr1_o[17] == (tt_i == '0))
                else $error("R8 trap bit");
        end
        if (op_i == 2'b10) begin
            a_r9_sc_cause: assert (srr1_o[21:16] == 6'b0)
                else $error("R9 syscall cause bits");
        end
    end
endmodule

bind exc_entry_gen exc_entry_chk u_chk (.*);

// File: tb/exc_entry_gen_bench.sv
module exc_entry_gen_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic [1:0]  op;
    logic [63:0] msr_in, pc;
    logic [4:0]  tt;
    logic [63:0] msr_out, srr1_out, srr0_out, nia_out;
    logic        msr_ok, srr1_ok, srr0_ok, nia_ok;
    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    exc_entry_gen u_exc_entry_gen (
        .op_i(op), .msr_i(msr_in), .tt_i(tt), .pc_i(pc),
        .msr_o(msr_out), .msr_ok_o(msr_ok),
        .srr1_o(srr1_out), .srr1_ok_o(srr1_ok),
        .srr0_o(srr0_out), .srr0_ok_o(srr0_ok),
        .nia_o(nia_out), .nia_ok_o(nia_ok)
    );

    function automatic logic [63:0] setb(logic [63:0] v, int n, logic b);
        logic [63:0] r;
        r = v;
        r[63-n] = b;
        return r;
    endfunction

    function automatic logic [63:0] exp_msr(logic [63:0] m);
        logic [63:0] r;
        int zl[15] = '{31, 38, 40, 48, 49, 50, 52, 53, 54, 55, 58, 59, 61, 62, 5};
        r = m;
        foreach (zl[i]) r = setb(r, zl[i], 1'b0);
        r = setb(r, 0, 1'b1);
        r = setb(r, 63, 1'b1);
        return r;
    endfunction

    function automatic logic [63:0] exp_srr1(logic [63:0] m, logic [4:0] t, logic prog);
        logic [63:0] r;
        r = m;
        for (int b = 33; b <= 36; b++) r = setb(r, b, 1'b0);
        for (int b = 42; b <= 47; b++) r = setb(r, b, 1'b0);
        if (prog) begin
            r = setb(r, 43, t[0]);
            r = setb(r, 44, t[4]);
            r = setb(r, 45, t[1]);
            r = setb(r, 46, t == 5'd0);
            r = setb(r, 47, t[3]);
        end
        return r;
    endfunction

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic apply(logic [1:0] o, logic [63:0] m, logic [4:0] t, logic [63:0] p);
        @(negedge clk);
        op = o; msr_in = m; tt = t; pc = p;
        #1;
    endtask

    task automatic test_idle(logic [1:0] code);
        apply(code, 64'hFFFF_FFFF_FFFF_FFFF, 5'h1F, 64'h1234);
        chk("R1 msr", msr_out, 64'h0);
        chk("R1 srr1", srr1_out, 64'h0);
        chk("R1 srr0", srr0_out, 64'h0);
        chk("R1 nia", nia_out, 64'h0);
        chk("R1 strobes", {60'h0, msr_ok, srr1_ok, srr0_ok, nia_ok}, 64'h0);
    endtask

    task automatic test_prog(logic [63:0] m, logic [4:0] t);
        apply(2'b01, m, t, 64'hDEAD_BEEF_0000_1000);
        chk("R2 strobes", {60'h0, msr_ok, srr1_ok, srr0_ok, nia_ok}, 64'hF);
        chk("R3 R4 R5 msr", msr_out, exp_msr(m));
        chk("R6 R7 R8 srr1", srr1_out, exp_srr1(m, t, 1'b1));
        chk("R10 srr0", srr0_out, 64'hDEAD_BEEF_0000_1000);
        chk("R10 nia prog", nia_out, 64'h700);
    endtask

    task automatic test_sc(logic [63:0] m, logic [4:0] t);
        apply(2'b10, m, t, 64'h0000_0000_0040_0004);
        chk("R2 strobes sc", {60'h0, msr_ok, srr1_ok, srr0_ok, nia_ok}, 64'hF);
        chk("R3 R4 R5 msr sc", msr_out, exp_msr(m));
        chk("R9 srr1 sc", srr1_out, exp_srr1(m, t, 1'b0));
        chk("R10 srr0 sc", srr0_out, 64'h0000_0000_0040_0004);
        chk("R10 nia sc", nia_out, 64'hC00);
    endtask

    task automatic test_hv_me();
        logic [63:0] m;
        m = setb(64'h0, 3, 1'b1);
        m = setb(m, 51, 1'b1);
        m = setb(m, 34, 1'b1);
        apply(2'b01, m, 5'd0, 64'h0);
        chk("R5 hv me ts copy", msr_out & 64'h1000_0000_2000_1000, 64'h1000_0000_2000_1000);
        chk("R8 trap bit tt=0", {63'h0, srr1_out[63-46]}, 64'h1);
        apply(2'b01, m, 5'b00100, 64'h0);
        chk("R7 tt bit2 ignored", srr1_out, exp_srr1(m, 5'b00100, 1'b1));
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        op = 2'b00; msr_in = '0; tt = '0; pc = '0;
        test_idle(2'b00);
        test_idle(2'b11);
        test_prog(64'h0, 5'd0);
        for (int i = 0; i < 5; i++) test_prog(64'h0, 5'(1 << i));
        test_prog(64'hFFFF_FFFF_FFFF_FFFF, 5'd0);
        test_prog(64'hFFFF_FFFF_FFFF_FFFF, 5'h1B);
        test_prog(64'hA5A5_5A5A_C3C3_3C3C, 5'h11);
        test_sc(64'hFFFF_FFFF_FFFF_FFFF, 5'h1F);
        test_sc(64'h0F0F_F0F0_1234_5678, 5'd0);
        test_hv_me();
        test_idle(2'b00);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule